// File: doc/BRIEF.md
# Interrupt Controller with Software Injection Lockout

This block gathers up to 32 interrupt request lines into one status register and raises a single combined request toward the processor. Each line is captured either as a level or as a rising edge. The choice is made per line at elaboration time. Software sees four word-addressed registers through a plain read/write port. The status register shows pending lines. The acknowledge register clears them. The enable register picks which pending lines may reach the output. The master control register holds the global output enable and the hardware-mode bit.

Until the hardware-mode bit is set, the request lines are ignored. Instead, software may inject pending bits by writing the status register. This lets drivers and diagnostics exercise the controller with no device attached. Setting the hardware-mode bit hands the status register over to the real lines for good. Only a reset can return the controller to injection mode, so a stray write cannot fake an interrupt on a running system.

Top module: `irq_sim_ctrl`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: Word address 0 selects status, 1 selects acknowledge, 2 selects enable and 3 selects master control. `rd_data_o` shows the selected register in the same cycle that `rd_en_i` is high, and shows zero while `rd_en_i` is low.
- R3: While hardware mode is off, a write to status ORs the written bits into the bits already pending, and a read returns the combined value.
- R4: A write to acknowledge clears exactly the written status bits and leaves the others alone. Acknowledge always reads as zero.
- R5: Master control bit 1 is the hardware-mode bit. Writing 1 sets it, and no later write clears it before reset. Bit 0 is the master output enable, which can be written either way. Both bits read back.
- R6: Once hardware mode is on, writes to status change nothing.
- R7: While hardware mode is off, the request lines never set status bits.
- R8: In hardware mode, a level-type line sets its status bit on every clock edge where it is high. An acknowledge therefore does not clear the bit while the line stays high.
- R9: In hardware mode, an edge-type line (its bit set in `EDGE_SEL`) sets its status bit only on the clock edge after the line goes from 0 to 1. Acknowledging the bit while the line is still high clears it.
- R10: If an acknowledge and a new capture hit the same bit in the same cycle, the bit stays set.
- R11: `irq_o` is high exactly when master enable is 1 and at least one bit is set in both status and enable.
- R12: The enable register stores and returns all of its bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address of the register |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | DATA_W | Read data, combinational |
| irq_src_i | input | N_SRC | Interrupt request lines |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that a write and a read never both target acknowledge in a way that changes state. They also assume the request lines are synchronous to `clk_i`. Under these assumptions, any bit that appears in status must come from a software write in injection mode or from a captured line in hardware mode. The stimulus changes `irq_src_i` and the strobes only on falling clock edges. It uses only the four defined addresses. It holds each line steady for several cycles, so every bit that appears can be traced to a single cause.

// File: rtl/irq_sim_pkg.sv
package irq_sim_pkg;
  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_ACK  = 2'd1,
    REG_ENA  = 2'd2,
    REG_MCTL = 2'd3
  } reg_sel_e;

  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned MCTL_ME  = 0;
  localparam int unsigned MCTL_HW  = 1;
endpackage

// File: rtl/irq_sim_decode.sv
module irq_sim_decode
  import irq_sim_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  output logic [NUM_REGS-1:0] wr_sel_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign wr_sel_o[g] = wr_en_i && (addr_i == ADDR_W'(g));
  end

  // R2
  wr_sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel_o));
endmodule

// File: rtl/irq_sim_src.sv
module irq_sim_src #(
  parameter int unsigned       N_SRC    = 32,
  parameter logic [N_SRC-1:0]  EDGE_SEL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_en_i,
  input  logic [N_SRC-1:0] irq_src_i,
  output logic [N_SRC-1:0] hit_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    if (EDGE_SEL[g]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= irq_src_i[g];
      end
      assign hit_o[g] = hw_en_i && irq_src_i[g] && !prev_q;
    end else begin : g_level
      assign hit_o[g] = hw_en_i && irq_src_i[g];
    end
  end

  // R7
  no_hit_sim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_en_i |-> (hit_o == '0));
endmodule

// File: rtl/irq_sim_status.sv
module irq_sim_status #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_en_i,
  input  logic             sw_wr_i,
  input  logic             ack_wr_i,
  input  logic [N_SRC-1:0] wdata_i,
  input  logic [N_SRC-1:0] hit_i,
  output logic [N_SRC-1:0] stat_o
);
  logic [N_SRC-1:0] stat_q, clr, inj;

  assign clr = ack_wr_i ? wdata_i : '0;
  assign inj = (sw_wr_i && !hw_en_i) ? wdata_i : '0;

  // capture after clear: simultaneous ack and hit leaves bit set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr) | inj | hit_i;
  end

  assign stat_o = stat_q;

  // R3
  inject_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_wr_i && !hw_en_i) |=> ((stat_q & $past(wdata_i)) == $past(wdata_i)));
  // R4
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_wr_i && !hw_en_i) |=> ((stat_q & $past(wdata_i)) == '0));
  // R6
  locked_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_en_i && sw_wr_i && hit_i == '0) |=> ((stat_q & ~$past(stat_q)) == '0));
  // R10
  ack_vs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i != '0) |=> ((stat_q & $past(hit_i)) == $past(hit_i)));
endmodule

// File: rtl/irq_sim_mctl.sv
module irq_sim_mctl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  output logic       me_o,
  output logic       hw_en_o
);
  logic me_q, hw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      me_q <= 1'b0;
      hw_q <= 1'b0;
    end else if (wr_i) begin
      me_q <= wdata_i[0];
      hw_q <= hw_q | wdata_i[1];
    end
  end

  assign me_o    = me_q;
  assign hw_en_o = hw_q;

  // R5
  hw_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_q |=> hw_q);
endmodule

// File: rtl/irq_sim_ctrl.sv
module irq_sim_ctrl
  import irq_sim_pkg::*;
#(
  parameter int unsigned      N_SRC    = 32,
  parameter int unsigned      DATA_W   = 32,
  parameter int unsigned      ADDR_W   = 2,
  parameter logic [N_SRC-1:0] EDGE_SEL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [N_SRC-1:0]  irq_src_i,
  output logic              irq_o
);
  logic [NUM_REGS-1:0] wr_sel;
  logic [N_SRC-1:0]    hit, stat, ena_q;
  logic                me, hw_en;

  irq_sim_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wr_sel_o(wr_sel)
  );

  irq_sim_src #(.N_SRC(N_SRC), .EDGE_SEL(EDGE_SEL)) u_src (
    .clk_i, .rst_ni, .hw_en_i(hw_en), .irq_src_i, .hit_o(hit)
  );

  irq_sim_status #(.N_SRC(N_SRC)) u_stat (
    .clk_i, .rst_ni, .hw_en_i(hw_en),
    .sw_wr_i(wr_sel[REG_STAT]), .ack_wr_i(wr_sel[REG_ACK]),
    .wdata_i(wr_data_i[N_SRC-1:0]), .hit_i(hit), .stat_o(stat)
  );

  irq_sim_mctl u_mctl (
    .clk_i, .rst_ni, .wr_i(wr_sel[REG_MCTL]),
    .wdata_i({wr_data_i[MCTL_HW], wr_data_i[MCTL_ME]}),
    .me_o(me), .hw_en_o(hw_en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ena_q <= '0;
    else if (wr_sel[REG_ENA]) ena_q <= wr_data_i[N_SRC-1:0];
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      unique case (reg_sel_e'(addr_i))
        REG_STAT: rd_data_o[N_SRC-1:0] = stat;
        REG_ENA:  rd_data_o[N_SRC-1:0] = ena_q;
        REG_MCTL: begin
          rd_data_o[MCTL_ME] = me;
          rd_data_o[MCTL_HW] = hw_en;
        end
        default:  rd_data_o = '0;
      endcase
    end
  end

  assign irq_o = me && ((stat & ena_q) != '0);

  // R11
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!me || stat == '0) |-> !irq_o);
  // R4
  ack_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_W'(REG_ACK)) |-> (rd_data_o == '0));
  // R2
  idle_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rd_data_o == '0));
endmodule

// File: tb/irq_sim_ctrl_tb_top.sv
module irq_sim_ctrl_tb_top;
  localparam logic [31:0] EDGE = 32'hF000_0000;
  localparam logic [1:0] A_STAT = 2'd0, A_ACK = 2'd1, A_ENA = 2'd2, A_MCTL = 2'd3;

  typedef struct packed {
    logic        wr;
    logic [1:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0, A_STAT, 32'h0, 32'h0, 8'd1},                 // R1
    '{1'b0, A_MCTL, 32'h0, 32'h0, 8'd1},                 // R1
    '{1'b1, A_STAT, 32'h0000_0001, 32'h0, 8'd3},         // R3 inject
    '{1'b0, A_STAT, 32'h0, 32'h0000_0001, 8'd3},         // R3
    '{1'b1, A_STAT, 32'h8000_0010, 32'h0, 8'd3},
    '{1'b0, A_STAT, 32'h0, 32'h8000_0011, 8'd3},         // R3 OR merge
    '{1'b0, A_ACK,  32'h0, 32'h0, 8'd4},                 // R4 ack reads 0
    '{1'b1, A_ACK,  32'h0000_0011, 32'h0, 8'd4},
    '{1'b0, A_STAT, 32'h0, 32'h8000_0000, 8'd4},         // R4 exact clear
    '{1'b1, A_ENA,  32'h8000_0000, 32'h0, 8'd12},
    '{1'b0, A_ENA,  32'h0, 32'h8000_0000, 8'd12}         // R12
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  logic [31:0] irq_src = '0;
  logic        irq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_sim_ctrl #(.EDGE_SEL(EDGE)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .irq_src_i(irq_src), .irq_o(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); rd_en = 1'b0; wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b1; addr = a;
    #1 check(rd_data, exp, req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    #1 check({31'b0, irq}, 32'h0, "R1");
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
      else rd(VEC[i].addr, VEC[i].exp, $sformatf("R%0d", VEC[i].req));
    end

    // R11: output gated by master enable
    idle(1); #1 check({31'b0, irq}, 32'h0, "R11");
    wr(A_MCTL, 32'h1);
    #1 check({31'b0, irq}, 32'h1, "R11");
    // R2: rd_en low gives zero
    rd_en = 1'b0; #1 check(rd_data, 32'h0, "R2");
    wr(A_ACK, 32'h8000_0000);
    #1 check({31'b0, irq}, 32'h0, "R11");

    // R7: lines ignored before hardware mode
    irq_src = 32'h0000_0004;
    idle(2);
    rd(A_STAT, 32'h0, "R7");

    // R5: write-once hardware bit
    wr(A_MCTL, 32'h3);
    rd(A_MCTL, 32'h3, "R5");
    wr(A_MCTL, 32'h0);
    rd(A_MCTL, 32'h2, "R5");

    // R8: level line captured, survives ack while high
    rd(A_STAT, 32'h4, "R8");
    wr(A_ACK, 32'h4);
    rd(A_STAT, 32'h4, "R10");
    irq_src = '0;
    wr(A_ACK, 32'h4);
    rd(A_STAT, 32'h0, "R4");

    // R6: injection locked
    wr(A_STAT, 32'h0000_000F);
    rd(A_STAT, 32'h0, "R6");

    // R9: edge line bit 28
    @(negedge clk); rd_en = 1'b0; irq_src = 32'h1000_0000;
    idle(2);
    rd(A_STAT, 32'h1000_0000, "R9");
    wr(A_ACK, 32'h1000_0000);
    idle(2);
    rd(A_STAT, 32'h0, "R9");
    irq_src = '0; idle(2);
    irq_src = 32'h1000_0000; idle(2);
    rd(A_STAT, 32'h1000_0000, "R9");

    // R11: enabled source with master enable
    wr(A_ENA, 32'h1000_0000);
    #1 check({31'b0, irq}, 32'h0, "R11");
    wr(A_MCTL, 32'h1);
    #1 check({31'b0, irq}, 32'h1, "R11");

    // R1: reset clears everything, including hardware mode
    @(negedge clk); rst_ni = 1'b0; irq_src = '0;
    idle(2); rst_ni = 1'b1;
    rd(A_MCTL, 32'h0, "R1");
    rd(A_STAT, 32'h0, "R1");
    rd(A_ENA, 32'h0, "R1");
    #1 check({31'b0, irq}, 32'h0, "R1");
    wr(A_STAT, 32'h0000_0100);
    rd(A_STAT, 32'h0000_0100, "R3");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule